// File: doc/BRIEF.md
# Serial programming command interpreter for on-chip non-volatile storage

This block is the device-side command register and decoder used to program and read non-volatile storage through a boundary-scan test port. During Shift-DR a 15-bit word enters on `tdi`, least significant bit first, and the previous contents leave on `tdo`. At Capture-DR the register loads the result of the command before it: a completion flag and one read byte. At Update-DR the word is split into a 7-bit strobe field (bits 14:8) and an 8-bit operand (bits 7:0). The strobe field is decoded into a mode selection, address and data loads, page-buffer latches, write starts and read steps.

Writes and reads do not follow single opcodes. They fire on transitions of particular strobe bits between the accepted command and the one accepted before it. The command interpreter is a state machine whose states are the operating modes: `MD_NOP`, `MD_ERASE`, `MD_FL_WR`, `MD_FL_RD`, `MD_EE_WR`, `MD_EE_RD`, `MD_FU_WR`, `MD_LK_WR`, `MD_FL_LK_RD` and `MD_SIG_RD`. There is one transition rule. From any state, an accepted mode-select strobe (`0100011`) moves the machine to the state its operand names. An unknown operand moves it to `MD_NOP`. Every other strobe leaves the state unchanged.

The storage model holds a word-wide flash array, a byte-wide EEPROM array, a page buffer, two fuse bytes and a lock byte. Each write or erase starts a busy timer of fixed length. The TAP controller and the programming-enable qualification are outside the block, and their results arrive as inputs.

Top module: `nvm_jtag_prog`

## Requirements
- R1: Capture-DR loads the word {5'b0, done, 1'b0, rd_byte}, which places the done flag at bit 9. Shift-DR moves `tdi` into bit 14 and shifts the word right. `tdo` always shows bit 0. After reset the word captures as 15'h0200.
- R2: Strobe `0100011` selects the mode from the operand. The codes are 0x80 erase, 0x10 flash write, 0x02 flash read, 0x11 EEPROM write, 0x03 EEPROM read, 0x40 fuse write, 0x20 lock write, 0x04 fuse/lock read, 0x08 signature/calibration read and 0x00 no operation. Any other code selects no operation, and in that mode no write is started.
- R3: The operand is loaded by four strobes: `0000111` into the address high byte, `0000011` into the address low byte, `0010011` into the data low byte and `0010111` into the data high byte.
- R4: In flash-write or EEPROM-write mode, strobe `1110111` accepted after a strobe whose bit 6 was 0 copies {data high, data low} into the page-buffer slot given by the low address bits.
- R5: Strobe `0110101` accepted after a strobe whose bit 1 was 1 commits the filled buffer slots to the flash page given by the address, when in flash-write mode. Strobe `0110001` under the same condition commits the filled slots' low bytes to the EEPROM page, when in EEPROM-write mode.
- R6: In fuse-write mode, the `0110101` edge writes the data low byte to the high fuse and the `0110001` edge writes it to the low fuse. In lock-write mode the `0110001` edge writes the data low byte with bits 7:6 forced to 1.
- R7: In erase mode the `0110001` edge sets every flash word to 16'hFFFF and every EEPROM byte and the lock byte to 8'hFF. The fuses are kept.
- R8: Each write or erase start makes the block busy for BUSY_CYCLES clocks, and done reads 0 during that time. An Update-DR that arrives while busy changes nothing.
- R9: In flash-read mode, `0110110` after `0110010` loads the low byte of the addressed word into rd_byte. `0110111` after `0110110` loads the high byte.
- R10: In EEPROM-read mode, `0110011` after `0110010` loads the addressed EEPROM byte.
- R11: In fuse/lock-read mode, `0111111` after `0111110` returns the high fuse, `0110011` after `0110010` returns the low fuse, and `0110111` after `0110110` returns the lock byte.
- R12: In signature mode, `0110011` after `0110010` returns signature byte number address[1:0], and `0110111` after `0110110` returns the calibration byte.
- R13: Address bits above the flash index width (9 bits by default) and above the EEPROM index width (7 bits by default) are ignored.
- R14: An Update-DR with `prog_en` low is ignored. After reset the mode is no operation, done is 1, rd_byte is 0, the memories and the lock byte read as all ones, and the fuses hold their parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Programming access granted |
| capture_dr | input | 1 | TAP in Capture-DR with this register selected |
| shift_dr | input | 1 | TAP in Shift-DR with this register selected |
| update_dr | input | 1 | TAP in Update-DR with this register selected |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the register |

## Verification
Two things can fall on the same edge: the busy timer running out, and the Capture-DR that samples the done flag or the Update-DR whose acceptance depends on busy. Before every command the bench inserts a random idle gap, so status captures and strobes land on either side of the expiry edge. For each capture the bench computes the expected done flag from the number of edges between the write-start update and the capture. A strobe sent while busy must leave the address untouched, and the bench observes this through a later read.

// File: rtl/nvm_jtag_pkg.sv
package nvm_jtag_pkg;

    localparam int CMD_W = 15;
    localparam int STB_W = 7;
    localparam int FLD_W = 8;

    typedef enum logic [3:0] {
        MD_NOP, MD_ERASE, MD_FL_WR, MD_FL_RD, MD_EE_WR,
        MD_EE_RD, MD_FU_WR, MD_LK_WR, MD_FL_LK_RD, MD_SIG_RD
    } mode_e;

    typedef enum logic [3:0] {
        RS_NONE, RS_FL_LO, RS_FL_HI, RS_EE, RS_FUSE_H,
        RS_FUSE_L, RS_LOCK, RS_SIG, RS_CAL
    } rdsel_e;

    localparam logic [STB_W-1:0] STB_MODE   = 7'b0100011;
    localparam logic [STB_W-1:0] STB_ADDR_H = 7'b0000111;
    localparam logic [STB_W-1:0] STB_ADDR_L = 7'b0000011;
    localparam logic [STB_W-1:0] STB_DATA_L = 7'b0010011;
    localparam logic [STB_W-1:0] STB_DATA_H = 7'b0010111;
    localparam logic [STB_W-1:0] STB_LATCH  = 7'b1110111;
    localparam logic [STB_W-1:0] STB_WR_H   = 7'b0110101;
    localparam logic [STB_W-1:0] STB_WR_L   = 7'b0110001;
    localparam logic [STB_W-1:0] STB_RD_A   = 7'b0110010;
    localparam logic [STB_W-1:0] STB_RD_B   = 7'b0110110;
    localparam logic [STB_W-1:0] STB_IDLE_H = 7'b0110111;
    localparam logic [STB_W-1:0] STB_IDLE_L = 7'b0110011;
    localparam logic [STB_W-1:0] STB_FH_A   = 7'b0111110;
    localparam logic [STB_W-1:0] STB_FH_B   = 7'b0111111;

    function automatic mode_e decode_mode(input logic [FLD_W-1:0] code);
        mode_e m;
        case (code)
            8'h80:   m = MD_ERASE;
            8'h10:   m = MD_FL_WR;
            8'h02:   m = MD_FL_RD;
            8'h11:   m = MD_EE_WR;
            8'h03:   m = MD_EE_RD;
            8'h40:   m = MD_FU_WR;
            8'h20:   m = MD_LK_WR;
            8'h04:   m = MD_FL_LK_RD;
            8'h08:   m = MD_SIG_RD;
            default: m = MD_NOP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/jtag_cmd_sr.sv
module jtag_cmd_sr
    import nvm_jtag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             shift,
    input  logic             tdi,
    input  logic             done,
    input  logic [FLD_W-1:0] rd_byte,
    output logic [CMD_W-1:0] word,
    output logic             tdo
);

    logic [CMD_W-1:0] cap_val;

    // Status bit sits in position 9, one above the strobe field's LSB.
    assign cap_val = {5'b0, done, 1'b0, rd_byte};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (capture) begin
            word <= cap_val;
        end else if (shift) begin
            word <= {tdi, word[CMD_W-1:1]};
        end
    end

    assign tdo = word[0];

endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/nvm_cmd_decoder.sv
module nvm_cmd_decoder
    import nvm_jtag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] word,
    input  logic             update,
    input  logic             prog_en,
    input  logic             busy,
    output mode_e            mode,
    output logic [15:0]      addr,
    output logic [15:0]      data,
    output logic             ev_latch,
    output logic             ev_fl_commit,
    output logic             ev_ee_commit,
    output logic             ev_fuse_h,
    output logic             ev_fuse_l,
    output logic             ev_lock,
    output logic             ev_erase,
    output logic             start,
    output rdsel_e           rd_sel
);

    logic [STB_W-1:0] stb;
    logic [FLD_W-1:0] fld;
    logic [STB_W-1:0] prev_q;
    logic             accept;
    logic             fall_h, fall_l, rise_latch;
    logic             after_ra, after_rb, after_fa;
    mode_e            mode_q, mode_d;

    assign stb    = word[CMD_W-1:FLD_W];
    assign fld    = word[FLD_W-1:0];
    assign accept = update && prog_en && !busy;

    assign fall_h     = accept && (stb == STB_WR_H) && prev_q[1];
    assign fall_l     = accept && (stb == STB_WR_L) && prev_q[1];
    assign rise_latch = accept && (stb == STB_LATCH) && !prev_q[6];
    assign after_ra   = (prev_q == STB_RD_A);
    assign after_rb   = (prev_q == STB_RD_B);
    assign after_fa   = (prev_q == STB_FH_A);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MD_NOP;
        else        mode_q <= mode_d;
    end

    // Next state
    always_comb begin
        mode_d = mode_q;
        if (accept && (stb == STB_MODE)) mode_d = decode_mode(fld);
    end

    // Operand registers and strobe history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            addr   <= '0;
            data   <= '0;
        end else if (accept) begin
            prev_q <= stb;
            if (stb == STB_ADDR_H) addr[15:8] <= fld;
            if (stb == STB_ADDR_L) addr[7:0]  <= fld;
            if (stb == STB_DATA_L) data[7:0]  <= fld;
            if (stb == STB_DATA_H) data[15:8] <= fld;
        end
    end

    // Outputs per state
    always_comb begin
        ev_latch     = 1'b0;
        ev_fl_commit = 1'b0;
        ev_ee_commit = 1'b0;
        ev_fuse_h    = 1'b0;
        ev_fuse_l    = 1'b0;
        ev_lock      = 1'b0;
        ev_erase     = 1'b0;
        rd_sel       = RS_NONE;
        unique case (mode_q)
            MD_NOP: ;
            MD_ERASE: ev_erase = fall_l;
            MD_FL_WR: begin
                ev_latch     = rise_latch;
                ev_fl_commit = fall_h;
            end
            MD_EE_WR: begin
                ev_latch     = rise_latch;
                ev_ee_commit = fall_l;
            end
            MD_FU_WR: begin
                ev_fuse_h = fall_h;
                ev_fuse_l = fall_l;
            end
            MD_LK_WR: ev_lock = fall_l;
            MD_FL_RD: begin
                if (accept && stb == STB_RD_B && after_ra)        rd_sel = RS_FL_LO;
                else if (accept && stb == STB_IDLE_H && after_rb) rd_sel = RS_FL_HI;
            end
            MD_EE_RD: begin
                if (accept && stb == STB_IDLE_L && after_ra) rd_sel = RS_EE;
            end
            MD_FL_LK_RD: begin
                if (accept && stb == STB_FH_B && after_fa)        rd_sel = RS_FUSE_H;
                else if (accept && stb == STB_IDLE_L && after_ra) rd_sel = RS_FUSE_L;
                else if (accept && stb == STB_IDLE_H && after_rb) rd_sel = RS_LOCK;
            end
            MD_SIG_RD: begin
                if (accept && stb == STB_IDLE_L && after_ra)      rd_sel = RS_SIG;
                else if (accept && stb == STB_IDLE_H && after_rb) rd_sel = RS_CAL;
            end
            default: ;
        endcase
    end

    assign start = ev_fl_commit | ev_ee_commit | ev_fuse_h | ev_fuse_l | ev_lock | ev_erase;
    assign mode  = mode_q;

endmodule

// File: rtl/nvm_store.sv
module nvm_store
    import nvm_jtag_pkg::*;
#(
    parameter int          FLASH_WORDS = 512,
    parameter int          EE_BYTES    = 128,
    parameter int          PAGE_SLOTS  = 4,
    parameter logic [7:0]  FUSE_H_INIT = 8'h99,
    parameter logic [7:0]  FUSE_L_INIT = 8'hE1,
    parameter logic [31:0] SIG_BYTES   = 32'hFF_03_94_1E,
    parameter logic [7:0]  CAL_BYTE    = 8'hA5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic [15:0] data,
    input  logic        latch,
    input  logic        fl_commit,
    input  logic        ee_commit,
    input  logic        fuse_h_wr,
    input  logic        fuse_l_wr,
    input  logic        lock_wr,
    input  logic        erase,
    input  rdsel_e      rd_sel,
    output logic [7:0]  rd_byte,
    output logic [7:0]  lock_bits
);

    localparam int FAW = $clog2(FLASH_WORDS);
    localparam int EAW = $clog2(EE_BYTES);
    localparam int PB  = $clog2(PAGE_SLOTS);

    logic [15:0]           flash_mem [FLASH_WORDS];
    logic [7:0]            ee_mem    [EE_BYTES];
    logic [15:0]           pbuf      [PAGE_SLOTS];
    logic [PAGE_SLOTS-1:0] pvalid;
    logic [7:0]            fuse_h, fuse_l, lock_q;
    logic [7:0]            rd_next;

    logic [FAW-1:0]  fl_idx;
    logic [FAW-PB-1:0] fl_page;
    logic [EAW-1:0]  ee_idx;
    logic [EAW-PB-1:0] ee_page;
    logic [PB-1:0]   slot;
    logic            unused_addr_hi;

    assign fl_idx         = addr[FAW-1:0];
    assign fl_page        = addr[FAW-1:PB];
    assign ee_idx         = addr[EAW-1:0];
    assign ee_page        = addr[EAW-1:PB];
    assign slot           = addr[PB-1:0];
    assign unused_addr_hi = ^addr[15:FAW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < FLASH_WORDS; i++) flash_mem[i] <= 16'hFFFF;
            for (int i = 0; i < EE_BYTES; i++)    ee_mem[i]    <= 8'hFF;
            for (int i = 0; i < PAGE_SLOTS; i++)  pbuf[i]      <= 16'hFFFF;
            pvalid <= '0;
        end else if (erase) begin
            for (int i = 0; i < FLASH_WORDS; i++) flash_mem[i] <= 16'hFFFF;
            for (int i = 0; i < EE_BYTES; i++)    ee_mem[i]    <= 8'hFF;
            pvalid <= '0;
        end else if (fl_commit) begin
            for (int i = 0; i < PAGE_SLOTS; i++)
                if (pvalid[i]) flash_mem[{fl_page, PB'(i)}] <= pbuf[i];
            pvalid <= '0;
        end else if (ee_commit) begin
            for (int i = 0; i < PAGE_SLOTS; i++)
                if (pvalid[i]) ee_mem[{ee_page, PB'(i)}] <= pbuf[i][7:0];
            pvalid <= '0;
        end else if (latch) begin
            pbuf[slot]   <= data;
            pvalid[slot] <= 1'b1;
        end
    end

    always_comb begin
        rd_next = rd_byte;
        case (rd_sel)
            RS_FL_LO:  rd_next = flash_mem[fl_idx][7:0];
            RS_FL_HI:  rd_next = flash_mem[fl_idx][15:8];
            RS_EE:     rd_next = ee_mem[ee_idx];
            RS_FUSE_H: rd_next = fuse_h;
            RS_FUSE_L: rd_next = fuse_l;
            RS_LOCK:   rd_next = lock_q;
            RS_SIG:    rd_next = SIG_BYTES[{addr[1:0], 3'b000} +: 8];
            RS_CAL:    rd_next = CAL_BYTE;
            default:   rd_next = rd_byte;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fuse_h  <= FUSE_H_INIT;
            fuse_l  <= FUSE_L_INIT;
            lock_q  <= 8'hFF;
            rd_byte <= '0;
        end else begin
            if (fuse_h_wr) fuse_h <= data[7:0];
            if (fuse_l_wr) fuse_l <= data[7:0];
            if (lock_wr)   lock_q <= {2'b11, data[5:0]};
            if (erase)     lock_q <= 8'hFF;
            rd_byte <= rd_next;
        end
    end

    assign lock_bits = lock_q;

endmodule

// File: rtl/nvm_jtag_prog.sv
module nvm_jtag_prog
    import nvm_jtag_pkg::*;
#(
    parameter int          FLASH_WORDS = 512,
    parameter int          EE_BYTES    = 128,
    parameter int          PAGE_SLOTS  = 4,
    parameter int          BUSY_CYCLES = 40,
    parameter logic [7:0]  FUSE_H_INIT = 8'h99,
    parameter logic [7:0]  FUSE_L_INIT = 8'hE1,
    parameter logic [31:0] SIG_BYTES   = 32'hFF_03_94_1E,
    parameter logic [7:0]  CAL_BYTE    = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_en,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic tdi,
    output logic tdo
);

    logic [CMD_W-1:0] word;
    logic [7:0]       rd_byte, lock_bits;
    logic [15:0]      addr, data;
    logic             busy, start;
    logic             ev_latch, ev_fl_commit, ev_ee_commit;
    logic             ev_fuse_h, ev_fuse_l, ev_lock, ev_erase;
    mode_e            mode;
    rdsel_e           rd_sel;

    jtag_cmd_sr i_sr (
        .clk(clk), .rst_n(rst_n), .capture(capture_dr), .shift(shift_dr),
        .tdi(tdi), .done(!busy), .rd_byte(rd_byte), .word(word), .tdo(tdo)
    );

    nvm_cmd_decoder i_dec (
        .clk(clk), .rst_n(rst_n), .word(word), .update(update_dr),
        .prog_en(prog_en), .busy(busy), .mode(mode), .addr(addr), .data(data),
        .ev_latch(ev_latch), .ev_fl_commit(ev_fl_commit), .ev_ee_commit(ev_ee_commit),
        .ev_fuse_h(ev_fuse_h), .ev_fuse_l(ev_fuse_l), .ev_lock(ev_lock),
        .ev_erase(ev_erase), .start(start), .rd_sel(rd_sel)
    );

    nvm_store #(
        .FLASH_WORDS(FLASH_WORDS), .EE_BYTES(EE_BYTES), .PAGE_SLOTS(PAGE_SLOTS),
        .FUSE_H_INIT(FUSE_H_INIT), .FUSE_L_INIT(FUSE_L_INIT),
        .SIG_BYTES(SIG_BYTES), .CAL_BYTE(CAL_BYTE)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .latch(ev_latch),
        .fl_commit(ev_fl_commit), .ee_commit(ev_ee_commit), .fuse_h_wr(ev_fuse_h),
        .fuse_l_wr(ev_fuse_l), .lock_wr(ev_lock), .erase(ev_erase),
        .rd_sel(rd_sel), .rd_byte(rd_byte), .lock_bits(lock_bits)
    );

    nvm_busy_timer #(.CYCLES(BUSY_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
    );

endmodule

// File: rtl/nvm_jtag_prog_chk.sv
module nvm_jtag_prog_chk
    import nvm_jtag_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        prog_en,
    input logic        capture_dr,
    input logic        shift_dr,
    input logic        update_dr,
    input logic        tdi,
    input logic [14:0] word,
    input logic        busy,
    input logic        start,
    input logic [7:0]  rd_byte,
    input logic [7:0]  lock_bits,
    input mode_e       mode,
    input logic [15:0] addr,
    input logic [15:0] data,
    input logic [6:0]  wr_events
);

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr |=> word == {5'b0, !$past(busy), 1'b0, $past(rd_byte)});

    p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_dr && !capture_dr) |=> word == {$past(tdi), $past(word[14:1])});

    p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    p_frozen_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && update_dr) |=> ($stable(mode) && $stable(addr) && $stable(data)));

    p_ignore_disabled_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (update_dr && !prog_en) |=> ($stable(mode) && $stable(addr) && $stable(data)));

    p_lock_top_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_bits[7:6] == 2'b11);

    p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_events));

endmodule

bind nvm_jtag_prog nvm_jtag_prog_chk i_chk (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .word(word),
    .busy(busy), .start(start), .rd_byte(rd_byte), .lock_bits(lock_bits),
    .mode(mode), .addr(addr), .data(data),
    .wr_events({ev_latch, ev_fl_commit, ev_ee_commit, ev_fuse_h, ev_fuse_l, ev_lock, ev_erase})
);

// File: tb/test_nvm_jtag_prog.sv
`timescale 1ns/1ps
module test_nvm_jtag_prog;

    localparam int BUSY = 40;
    localparam int FW   = 512;
    localparam int EB   = 128;

    localparam logic [6:0] S_MODE = 7'b0100011, S_AH = 7'b0000111, S_AL = 7'b0000011,
                           S_DL = 7'b0010011, S_DH = 7'b0010111, S_LAT = 7'b1110111,
                           S_WH = 7'b0110101, S_WL = 7'b0110001, S_RA = 7'b0110010,
                           S_RB = 7'b0110110, S_IH = 7'b0110111, S_IL = 7'b0110011,
                           S_FA = 7'b0111110, S_FB = 7'b0111111;

    logic clk = 1'b0, rst_n = 1'b0, prog_en = 1'b1;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic tdo;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, t_cap = 0, t_upd = 0, t_trig = -1000;
    logic [15:0] fm [FW];
    logic [7:0]  em [EB];
    logic [7:0]  fh = 8'h99, fl = 8'hE1, lk = 8'hFF;
    logic [14:0] cap;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nvm_jtag_prog i_nvm_jtag_prog (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo)
    );

    function automatic int fidx(input logic [15:0] a); return int'(a[8:0]); endfunction
    function automatic int eidx(input logic [15:0] a); return int'(a[6:0]); endfunction
    function automatic logic exp_done(input int tc); return (tc - t_trig) > BUSY; endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cmd(input logic [6:0] s, input logic [7:0] f);
        logic [14:0] w;
        w = {s, f};
        repeat ($urandom_range(0, 3)) @(negedge clk);
        capture_dr = 1'b1; t_cap = cyc + 1;
        @(negedge clk);
        capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 15; i++) begin
            cap[i] = tdo;
            tdi = w[i];
            @(negedge clk);
        end
        shift_dr = 1'b0; update_dr = 1'b1; t_upd = cyc + 1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    task automatic poll(input logic [6:0] s);
        for (int k = 0; k < 10; k++) begin
            cmd(s, 8'h00);
            check("R8", "done flag", {31'b0, cap[9]}, {31'b0, exp_done(t_cap)});
            if (cap[9]) break;
        end
    endtask

    task automatic fl_write(input logic [15:0] base, input logic [63:0] dw);
        cmd(S_MODE, 8'h10);
        cmd(S_AH, base[15:8]);
        for (int i = 0; i < 4; i++) begin
            cmd(S_AL, base[7:0] | 8'(i));
            cmd(S_DL, dw[16*i +: 8]);
            cmd(S_DH, dw[16*i+8 +: 8]);
            cmd(S_IH, 8'h00); cmd(S_LAT, 8'h00); cmd(S_IH, 8'h00);
            fm[fidx(base | 16'(i))] = dw[16*i +: 16];
        end
        cmd(S_WH, 8'h00); t_trig = t_upd;
    endtask

    task automatic fl_read(input logic [15:0] a, input logic set_addr);
        cmd(S_MODE, 8'h02);
        if (set_addr) begin cmd(S_AH, a[15:8]); cmd(S_AL, a[7:0]); end
        cmd(S_RA, 8'h00); cmd(S_RB, 8'h00);
        cmd(S_IH, 8'h00);
        check("R9", "flash low byte", {24'b0, cap[7:0]}, {24'b0, fm[fidx(a)][7:0]});
        cmd(S_IH, 8'h00);
        check("R9", "flash high byte (R3 data high)", {24'b0, cap[7:0]}, {24'b0, fm[fidx(a)][15:8]});
    endtask

    task automatic ee_write(input logic [15:0] base, input logic [31:0] bw);
        cmd(S_MODE, 8'h11);
        cmd(S_AH, base[15:8]);
        for (int i = 0; i < 4; i++) begin
            cmd(S_AL, base[7:0] | 8'(i));
            cmd(S_DL, bw[8*i +: 8]);
            cmd(S_IH, 8'h00); cmd(S_LAT, 8'h00); cmd(S_IH, 8'h00);
            em[eidx(base | 16'(i))] = bw[8*i +: 8];
        end
        cmd(S_IL, 8'h00);
        cmd(S_WL, 8'h00); t_trig = t_upd;
        poll(S_IL);
    endtask

    task automatic ee_read(input logic [15:0] a);
        cmd(S_MODE, 8'h03);
        cmd(S_AH, a[15:8]); cmd(S_AL, a[7:0]);
        cmd(S_RA, 8'h00); cmd(S_IL, 8'h00);
        cmd(S_IL, 8'h00);
        check("R10", "eeprom byte", {24'b0, cap[7:0]}, {24'b0, em[eidx(a)]});
    endtask

    task automatic fuse_lock_read();
        cmd(S_MODE, 8'h04);
        cmd(S_FA, 8'h00); cmd(S_FB, 8'h00);
        cmd(S_RA, 8'h00);
        check("R11", "fuse high", {24'b0, cap[7:0]}, {24'b0, fh});
        cmd(S_IL, 8'h00);
        cmd(S_RB, 8'h00);
        check("R11", "fuse low", {24'b0, cap[7:0]}, {24'b0, fl});
        cmd(S_IH, 8'h00);
        cmd(S_IH, 8'h00);
        check("R11", "lock byte", {24'b0, cap[7:0]}, {24'b0, lk});
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [63:0] dw;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < FW; i++) fm[i] = 16'hFFFF;
        for (int i = 0; i < EB; i++) em[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R14: reset capture word
        cmd(S_MODE, 8'h00);
        check("R1", "reset capture word", {17'b0, cap}, 32'h0200);
        fl_read(16'h0123, 1'b1);

        // R4 R5 R13: random flash pages, read back through aliased high bits
        for (int n = 0; n < 5; n++) begin
            a  = {7'($urandom), 9'($urandom)} & 16'hFFFC;
            dw = {$urandom, $urandom};
            fl_write(a, dw);
            poll(S_IH);
            for (int i = 0; i < 4; i++) begin
                fl_read((a | 16'(i)) ^ 16'hFE00, 1'b1);
                check("R13", "flash alias word", {16'b0, fm[fidx((a | 16'(i)) ^ 16'hFE00)]}, {16'b0, dw[16*i +: 16]});
            end
        end

        // R8: address load during busy ignored; read back uses last slot
        a = 16'h0140;
        fl_write(a, 64'h1111_2222_3333_4444);
        cmd(S_AL, 8'h00);
        poll(S_IH);
        fl_read(a | 16'h3, 1'b0);

        // R5 R10 R13: EEPROM pages; write with bit 7 set, read with it cleared
        for (int n = 0; n < 3; n++) begin
            a = {8'($urandom), 8'($urandom) | 8'h80} & 16'hFFFC;
            ee_write(a, $urandom);
            for (int i = 0; i < 4; i++) ee_read((a | 16'(i)) & 16'h007F);
        end

        // R6: fuses and lock
        cmd(S_MODE, 8'h40);
        cmd(S_DL, 8'h5A); cmd(S_IH, 8'h00);
        cmd(S_WH, 8'h00); t_trig = t_upd; fh = 8'h5A;
        poll(S_IH);
        cmd(S_DL, 8'hC3); cmd(S_IL, 8'h00);
        cmd(S_WL, 8'h00); t_trig = t_upd; fl = 8'hC3;
        poll(S_IL);
        cmd(S_MODE, 8'h20);
        cmd(S_DL, 8'h15); cmd(S_IL, 8'h00);
        cmd(S_WL, 8'h00); t_trig = t_upd; lk = 8'hD5;
        poll(S_IL);
        fuse_lock_read();
        check("R6", "lock top bits forced", {30'b0, cap[7:6]}, 32'h3);

        // R12: signature bytes and calibration
        for (int k = 0; k < 4; k++) begin
            cmd(S_MODE, 8'h08);
            cmd(S_AL, 8'(k));
            cmd(S_RA, 8'h00); cmd(S_IL, 8'h00);
            cmd(S_RB, 8'h00);
            check("R12", "signature byte", {24'b0, cap[7:0]}, {24'b0, 32'hFF_03_94_1E >> (8 * k)} & 32'hFF);
            cmd(S_IH, 8'h00);
            cmd(S_IH, 8'h00);
            check("R12", "calibration byte", {24'b0, cap[7:0]}, 32'hA5);
        end

        // R2: unknown mode code acts as no operation
        cmd(S_MODE, 8'h55);
        cmd(S_IH, 8'h00); cmd(S_WH, 8'h00);
        cmd(S_IH, 8'h00);
        check("R2", "no busy after unknown mode", {31'b0, cap[9]}, 32'h1);

        // R14: commands ignored with programming disabled
        prog_en = 1'b0;
        cmd(S_MODE, 8'h80); cmd(S_WL, 8'h00);
        prog_en = 1'b1;
        cmd(S_IL, 8'h00);
        check("R14", "no erase when disabled", {31'b0, cap[9]}, 32'h1);
        ee_read(a);

        // R7: chip erase keeps fuses
        cmd(S_MODE, 8'h80);
        cmd(S_WL, 8'h80); t_trig = t_upd;
        poll(S_IL);
        for (int i = 0; i < FW; i++) fm[i] = 16'hFFFF;
        for (int i = 0; i < EB; i++) em[i] = 8'hFF;
        lk = 8'hFF;
        fl_read(16'h0140, 1'b1);
        check("R7", "flash erased", {16'b0, fm[fidx(16'h0140)]}, 32'hFFFF);
        ee_read(a);
        fuse_lock_read();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule